// File: doc/BRIEF.md
# SDRAM burst column sequencer

This block is the per-access column and data-lane sequencer inside a synchronous DRAM burst engine. Once a bank row is open, the command scheduler hands it a burst start: a starting column, a length of 4 or 8 beats, a wrap mode (sequential or interleaved), a read/write flag and a CAS latency of 2 or 3. From then on the sequencer issues one column per clock in the wrap order for that mode. It also produces the data-lane controls for each beat: a write-data accept strobe and a read-data output enable.

The first beat leaves in the same clock as the start command, so write data for beat 0 is taken with the command. A data-mask input blocks write data in the clock it is raised. On reads it turns the output to high impedance two clocks later. A burst-stop or precharge request ends the burst at once. Read data already in flight drains for CAS-latency clocks and then the lane goes to high impedance. A new start while a burst is running replaces that burst.

Top module: `burst_col_seq`

## Requirements
- R1: Sequential 4-beat burst: column bits [1:0] count up from the start value and wrap modulo 4, so start 1 gives 1,2,3,0 and start 2 gives 2,3,0,1. Bit [2] and all higher bits keep the start value.
- R2: Interleaved 4-beat burst: column bits [1:0] of beat k equal start[1:0] XOR k, so start 1 gives 1,0,3,2 and start 3 gives 3,2,1,0.
- R3: 8-beat bursts use column bits [2:0]. Sequential wraps modulo 8 (start 5 gives 5,6,7,0,1,2,3,4). Interleaved gives start XOR k (start 5 gives 5,4,7,6,1,0,3,2).
- R4: Column bits above the burst field hold their start value on every beat of a burst.
- R5: Beat 0 is issued in the same clock as start_i. On a write beat, wdata_en_o is high in that clock unless dqm_i is high in the same clock.
- R6: A read beat issued in clock t gives rdata_oe_o high in clock t+3 when cl3_i=1 at start, and in clock t+2 when cl3_i=0.
- R7: dqm_i high in clock c forces rdata_oe_o low in clock c+2.
- R8: stop_i (burst stop or precharge) issues no beat in its own clock and ends the burst. Read output goes low starting CAS-latency clocks after stop_i.
- R9: start_i during a running burst restarts the sequence from the new column and settings, with no done_o pulse in that clock.
- R10: stop_i and start_i together: stop wins, no beat is issued and the new start is dropped.
- R11: done_o pulses with the last beat (beat 3 or beat 7), or in a stop_i clock while a burst is running.
- R12: Length, wrap mode, direction and latency are taken at start; changes on bl8_i, ileave_i, wr_i or cl3_i during a burst have no effect.
- R13: After reset, beat_vld_o, done_o, wdata_en_o and rdata_oe_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst start command |
| col_i | input | COL_W | Starting column |
| bl8_i | input | 1 | 1: 8-beat burst, 0: 4-beat burst |
| ileave_i | input | 1 | 1: interleaved order, 0: sequential order |
| wr_i | input | 1 | 1: write burst, 0: read burst |
| cl3_i | input | 1 | 1: CAS latency 3, 0: CAS latency 2 |
| stop_i | input | 1 | Burst stop or precharge request |
| dqm_i | input | 1 | Data mask |
| beat_vld_o | output | 1 | A column is issued this clock |
| col_o | output | COL_W | Column of the current beat |
| done_o | output | 1 | Last beat or termination |
| wdata_en_o | output | 1 | Write data accepted this clock |
| rdata_oe_o | output | 1 | Read data driven this clock (0 = high impedance) |

## Verification
Three overlaps are provoked on purpose. A stop can arrive together with a new start, or in the middle of a read whose data is still in the latency pipe. A read mask can land on a clock where latency-delayed data would otherwise be driven. For each read case the bench builds an expected output-enable trace from the beat, mask and stop clocks and compares it clock by clock. In the stop-with-start clock the bench checks that no beat is issued, that done fires, and that the dropped start leaves the outputs idle in the next clock.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int unsigned OFS_W = 3;  // widest burst field (8 beats)

  typedef struct packed {
    logic len8;
    logic ileave;
    logic wr;
    logic cl3;
  } burst_cfg_t;
endpackage

// File: rtl/bcs_order.sv
module bcs_order
  import bcs_pkg::*;
(
  input  logic [OFS_W-1:0] start_lo_i,
  input  logic [OFS_W-1:0] beat_i,
  input  logic             len8_i,
  input  logic             ileave_i,
  output logic [OFS_W-1:0] lo_o
);
  logic [OFS_W-1:0] calc;

  always_comb begin
    calc = ileave_i ? (start_lo_i ^ beat_i) : (start_lo_i + beat_i);
    // 4-beat bursts keep bit 2 of the start column
    lo_o = len8_i ? calc : {start_lo_i[OFS_W-1], calc[OFS_W-2:0]};
  end
endmodule

// File: rtl/bcs_rd_lane.sv
module bcs_rd_lane #(
  parameter int unsigned MAX_CL = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  logic cl3_i,
  input  logic dqm_i,
  output logic oe_o
);
  logic [MAX_CL-1:0] d_q, d_nxt;
  logic [1:0]        m_q;
  int unsigned       slot;

  assign slot = cl3_i ? 32'd2 : 32'd1;

  for (genvar g = 0; g < MAX_CL; g++) begin : g_stage
    if (g == MAX_CL - 1) begin : g_top
      assign d_nxt[g] = issue_i && (slot == g);
    end else begin : g_mid
      assign d_nxt[g] = d_q[g+1] | (issue_i && (slot == g));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q <= '0;
      m_q <= '0;
    end else begin
      d_q <= d_nxt;
      m_q <= {m_q[0], dqm_i};
    end
  end

  assign oe_o = d_q[0] & ~m_q[1];

  a_r7_mask_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dqm_i, 2) |-> !oe_o);
  a_r6_oe_needs_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> ($past(issue_i, 2) || $past(issue_i, 3)));
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W  = 10,
  parameter int unsigned MAX_CL = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             bl8_i,
  input  logic             ileave_i,
  input  logic             wr_i,
  input  logic             cl3_i,
  input  logic             stop_i,
  input  logic             dqm_i,
  output logic             beat_vld_o,
  output logic [COL_W-1:0] col_o,
  output logic             done_o,
  output logic             wdata_en_o,
  output logic             rdata_oe_o
);
  localparam logic [OFS_W-1:0] LAST8 = OFS_W'(7);
  localparam logic [OFS_W-1:0] LAST4 = OFS_W'(3);

  logic             act_q;
  logic [OFS_W-1:0] k_q;
  logic [COL_W-1:0] base_q;
  burst_cfg_t       cfg_q;

  logic             take_new;
  logic [OFS_W-1:0] cur_k;
  logic [COL_W-1:0] cur_base;
  burst_cfg_t       cur_cfg;
  logic [OFS_W-1:0] cur_lo;
  logic             last;

  assign take_new   = start_i && !stop_i;
  assign beat_vld_o = !stop_i && (start_i || act_q);

  always_comb begin
    if (take_new) begin
      cur_k    = '0;
      cur_base = col_i;
      cur_cfg  = '{len8: bl8_i, ileave: ileave_i, wr: wr_i, cl3: cl3_i};
    end else begin
      cur_k    = k_q;
      cur_base = base_q;
      cur_cfg  = cfg_q;
    end
  end

  bcs_order u_order (
    .start_lo_i (cur_base[OFS_W-1:0]),
    .beat_i     (cur_k),
    .len8_i     (cur_cfg.len8),
    .ileave_i   (cur_cfg.ileave),
    .lo_o       (cur_lo)
  );

  assign col_o      = {cur_base[COL_W-1:OFS_W], cur_lo};
  assign last       = beat_vld_o && (cur_k == (cur_cfg.len8 ? LAST8 : LAST4));
  assign done_o     = last || (stop_i && act_q);
  assign wdata_en_o = beat_vld_o && cur_cfg.wr && !dqm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      k_q    <= '0;
      base_q <= '0;
      cfg_q  <= '0;
    end else if (stop_i) begin
      act_q <= 1'b0;
    end else if (beat_vld_o) begin
      act_q  <= !last;
      k_q    <= cur_k + 1'b1;
      base_q <= cur_base;
      cfg_q  <= cur_cfg;
    end
  end

  bcs_rd_lane #(.MAX_CL(MAX_CL)) u_rd_lane (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (beat_vld_o && !cur_cfg.wr),
    .cl3_i   (cur_cfg.cl3),
    .dqm_i   (dqm_i),
    .oe_o    (rdata_oe_o)
  );

  a_r8_stop_no_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> !beat_vld_o);
  a_r5_wen_in_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdata_en_o |-> (beat_vld_o && !dqm_i));
  a_r4_upper_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_vld_o && !start_i && $past(beat_vld_o)) |-> $stable(col_o[COL_W-1:OFS_W]));
  a_r11_done_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (beat_vld_o || stop_i));
  a_r8_idle_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!beat_vld_o || start_i));
endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 0, bl8_i = 0, ileave_i = 0, wr_i = 0, cl3_i = 0, stop_i = 0, dqm_i = 0;
  logic [9:0] col_i = '0;
  logic       beat_vld_o, done_o, wdata_en_o, rdata_oe_o;
  logic [9:0] col_o;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  burst_col_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .col_i(col_i), .bl8_i(bl8_i),
    .ileave_i(ileave_i), .wr_i(wr_i), .cl3_i(cl3_i), .stop_i(stop_i), .dqm_i(dqm_i),
    .beat_vld_o(beat_vld_o), .col_o(col_o), .done_o(done_o),
    .wdata_en_o(wdata_en_o), .rdata_oe_o(rdata_oe_o)
  );

  typedef struct packed {
    logic [9:0]      col;
    logic            bl8;
    logic            il;
    logic [0:7][2:0] ofs;
  } vec_t;

  // R1/R2/R3 expected column low bits per beat
  localparam vec_t VECS [8] = '{
    '{10'h001, 1'b0, 1'b0, {3'd1, 3'd2, 3'd3, 3'd0, 12'd0}},
    '{10'h002, 1'b0, 1'b0, {3'd2, 3'd3, 3'd0, 3'd1, 12'd0}},
    '{10'h001, 1'b0, 1'b1, {3'd1, 3'd0, 3'd3, 3'd2, 12'd0}},
    '{10'h003, 1'b0, 1'b1, {3'd3, 3'd2, 3'd1, 3'd0, 12'd0}},
    '{10'h0F5, 1'b1, 1'b0, {3'd5, 3'd6, 3'd7, 3'd0, 3'd1, 3'd2, 3'd3, 3'd4}},
    '{10'h0F5, 1'b1, 1'b1, {3'd5, 3'd4, 3'd7, 3'd6, 3'd1, 3'd0, 3'd3, 3'd2}},
    '{10'h1AE, 1'b0, 1'b0, {3'd6, 3'd7, 3'd4, 3'd5, 12'd0}},
    '{10'h3FA, 1'b1, 1'b1, {3'd2, 3'd3, 3'd0, 3'd1, 3'd6, 3'd7, 3'd4, 3'd5}}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic [9:0] c, input logic b8, input logic il,
                       input logic w, input logic c3, input logic stp, input logic m);
    @(negedge clk);
    start_i = s; col_i = c; bl8_i = b8; ileave_i = il; wr_i = w; cl3_i = c3;
    stop_i = stp; dqm_i = m;
    #2;
  endtask

  // R6/R7/R8: 4-beat read from column 0x100, mask and stop at chosen clocks (-1 = none)
  task automatic run_read(input string req, input logic c3, input int mcyc, input int scyc);
    int lat;
    lat = c3 ? 3 : 2;
    for (int i = 0; i < 10; i++) begin
      bit iss, oe_exp, dn_exp;
      int j;
      drive(i == 0, 10'h100, 1'b0, 1'b0, 1'b0, c3, i == scyc, i == mcyc);
      iss = (i < 4) && !(scyc >= 0 && i >= scyc);
      j = i - lat;
      oe_exp = (j >= 0) && (j < 4) && !(scyc >= 0 && j >= scyc) && !(mcyc >= 0 && i - 2 == mcyc);
      dn_exp = (i == 3 && iss) || (scyc >= 1 && scyc <= 3 && i == scyc);
      chk({req, " beat"}, beat_vld_o, iss);
      chk({req, " oe"}, rdata_oe_o, oe_exp);
      chk({req, " done"}, done_o, dn_exp);
      if (iss) chk({req, " col"}, col_o, 10'h100 + i);
    end
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #22;
    // R13 reset state
    chk("R13 beat", beat_vld_o, 0);
    chk("R13 done", done_o, 0);
    chk("R13 wen", wdata_en_o, 0);
    chk("R13 oe", rdata_oe_o, 0);
    rst_ni = 1'b1;

    // R1 R2 R3 R4 R5 R11: table walk as write bursts
    for (int v = 0; v < 8; v++) begin
      int len;
      len = VECS[v].bl8 ? 8 : 4;
      for (int b = 0; b < len; b++) begin
        drive(b == 0, VECS[v].col, VECS[v].bl8, VECS[v].il, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R1/R2/R3 beat", beat_vld_o, 1);
        chk("R1/R2/R3 R4 col", col_o, {VECS[v].col[9:3], VECS[v].ofs[b]});
        chk("R11 done", done_o, b == len - 1);
        chk("R5 wen", wdata_en_o, 1);
      end
      drive(0, 10'h0, 0, 0, 0, 0, 0, 0);
      chk("R11 idle", beat_vld_o, 0);
    end

    // R5: mask on beat 1 of a write blocks only that beat
    for (int b = 0; b < 4; b++) begin
      drive(b == 0, 10'h020, 0, 0, 1, 0, 0, b == 1);
      chk("R5 masked wen", wdata_en_o, b != 1);
    end
    drive(0, 10'h0, 0, 0, 0, 0, 0, 0);

    run_read("R6 cl3", 1'b1, -1, -1);
    run_read("R6 cl2", 1'b0, -1, -1);
    run_read("R7 cl3 mask", 1'b1, 1, -1);
    run_read("R7 cl2 mask", 1'b0, 3, -1);
    run_read("R8 cl3 stop", 1'b1, -1, 2);
    run_read("R8 cl2 stop", 1'b0, -1, 2);

    // R9: restart mid-burst
    drive(1, 10'h010, 1, 0, 1, 0, 0, 0);
    chk("R9 col0", col_o, 10'h010);
    drive(0, 10'h0, 0, 0, 0, 0, 0, 0);
    chk("R9 col1", col_o, 10'h011);
    for (int b = 0; b < 4; b++) begin
      drive(b == 0, 10'h023, 0, 1, 1, 0, 0, 0);
      chk("R9 beat", beat_vld_o, 1);
      chk("R9 col", col_o, {7'h04, 3'd3 ^ 3'(b)});
      chk("R9 done", done_o, b == 3);
    end
    drive(0, 10'h0, 0, 0, 0, 0, 0, 0);
    chk("R9 idle", beat_vld_o, 0);

    // R10: start and stop in the same clock during a burst
    drive(1, 10'h040, 0, 0, 1, 0, 0, 0);
    drive(1, 10'h055, 0, 0, 1, 0, 1, 0);
    chk("R10 no beat", beat_vld_o, 0);
    chk("R10 done", done_o, 1);
    chk("R10 wen", wdata_en_o, 0);
    drive(0, 10'h0, 0, 0, 0, 0, 0, 0);
    chk("R10 dropped", beat_vld_o, 0);

    // R12: settings changed mid-burst are ignored
    drive(1, 10'h000, 0, 0, 1, 0, 0, 0);
    chk("R12 col0", col_o, 10'h000);
    for (int b = 1; b < 4; b++) begin
      drive(0, 10'h0, 1, 1, 0, 1, 0, 0);
      chk("R12 col", col_o, 10'(b));
      chk("R12 wen", wdata_en_o, 1);
      chk("R12 done", done_o, b == 3);
    end
    drive(0, 10'h0, 1, 1, 0, 1, 0, 0);
    chk("R12 ends at 4", beat_vld_o, 0);
    drive(0, 10'h0, 0, 0, 0, 0, 0, 0);
    chk("R12 no read data", rdata_oe_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule